// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block tells the rename stage which earlier store, if any, a load should wait for before it issues. It learns from memory-ordering violations. Every load is first allowed to run ahead of older stores. When the core reports that a load overtook a store it depended on, the two instructions are grouped into one store set. After that, a renamed load whose set has an unexecuted store in flight is told the tag of that store.

Two tables hold the prediction state. The set-id table is indexed by instruction address bits `[PC_LSB +: log2(SET_TABLE_ENTRIES)]` (pc[7:2] at the defaults) and keeps a valid bit and a set id per entry. The newest-store table is indexed by set id and keeps a valid bit and the tag of the newest renamed store in each set. Several loads may share one set. Linking instructions that already sit in two different sets merges them into one.

All four request channels (load lookup, store rename, store execute, violation report) are valid-only streams with no back-pressure. Each request is taken in the cycle its valid is high. The load answer is combinational in that same cycle and reflects the table state as of the start of the cycle. Table updates from a cycle's requests become visible from the next cycle on. A clear input wipes all learned state.

Top module: `mem_dep_storeset`

## Requirements
- R1: After reset, `ld_wait_valid` is 0 for every load address, and `ld_wait_tag` is 0 whenever `ld_wait_valid` is 0.
- R2: Table entries are selected by pc[7:2] (64 entries). Two addresses that differ only outside those bits share training: a load at A+256 predicts the same as a load at A.
- R3: On a violation where neither the load nor the store address has a valid set, both are given the id held by a 4-bit allocation counter. The counter starts at 0, steps by one per such allocation and wraps from 15 to 0.
- R4: A load lookup asserts `ld_wait_valid` in the same cycle when its address has a valid set whose newest-store entry is valid, and drives that entry's tag on `ld_wait_tag`. Updates requested in the same cycle are not seen by the lookup.
- R5: A store rename whose address has a valid set records `st_req_tag` as that set's newest store, marks it valid, and is visible to loads from the next cycle. A store rename without a valid set changes nothing.
- R6: A store execute whose address has a valid set clears that set's newest-store entry only if the stored tag equals `st_exec_tag`. If a store rename writes the same set in the same cycle, the rename wins.
- R7: On a violation where only the store has a set, the load joins the store's set.
- R8: On a violation where only the load has a set, the store joins the load's set.
- R9: On a violation where both have different sets, both end up in the numerically smaller set id. If they already share a set, nothing changes.
- R10: `clear` invalidates every entry of both tables and resets the allocation counter to 0. It overrides every other request in the same cycle.
- R11: With `ld_req_valid` low, `ld_wait_valid` is 0 and `ld_wait_tag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_req_valid | input | 1 | Load lookup request |
| ld_req_pc | input | PC_W | Load instruction address |
| ld_wait_valid | output | 1 | Load must wait for the store named by `ld_wait_tag` |
| ld_wait_tag | output | TAG_W | Tag of the store to wait for, 0 when not waiting |
| st_req_valid | input | 1 | Store rename request |
| st_req_pc | input | PC_W | Renamed store address |
| st_req_tag | input | TAG_W | Tag given to the renamed store |
| st_exec_valid | input | 1 | Store execute notification |
| st_exec_pc | input | PC_W | Executed store address |
| st_exec_tag | input | TAG_W | Tag of the executed store |
| viol_valid | input | 1 | Memory-order violation report |
| viol_ld_pc | input | PC_W | Address of the violating load |
| viol_st_pc | input | PC_W | Address of the store it overtook |
| clear | input | 1 | Wipe all prediction state |

## Verification
A corrupted set id or valid bit in the set-id table only becomes visible when a load with that index is looked up. It then shows as a missing or spurious wait, or as a wait on the wrong tag, in that lookup cycle. A stale or wrongly cleared newest-store entry shows on the first load of its set after the faulty update, one cycle after the rename or execute that caused it. A wrong merge or allocation choice may stay hidden until a later rename into the affected set, so the bench mixes renames, executes and violations densely over a small pool of aliasing addresses. It compares every load answer against an independent model every cycle.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  // outcome of a violation report against the set-id table
  typedef enum logic [2:0] {
    VA_NONE,
    VA_NEW,
    VA_LD_JOIN,
    VA_ST_JOIN,
    VA_MERGE
  } viol_act_e;
endpackage

// File: rtl/ssp_set_table.sv
module ssp_set_table #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6,
  parameter int ID_W    = 4,
  parameter int NRD     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [IDX_W-1:0] rd_idx [NRD],
  output logic             rd_vld [NRD],
  output logic [ID_W-1:0]  rd_id  [NRD],
  input  logic             wa_en,
  input  logic [IDX_W-1:0] wa_idx,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic [ID_W-1:0]  wr_id
);
  logic [ENTRIES-1:0] vld;
  logic [ID_W-1:0]    ids [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      vld <= '0;
    end else begin
      if (wa_en) vld[wa_idx] <= 1'b1;
      if (wb_en) vld[wb_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !clr) begin
      if (wa_en) ids[wa_idx] <= wr_id;
      if (wb_en) ids[wb_idx] <= wr_id;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_vld[g] = vld[rd_idx[g]];
    assign rd_id[g]  = ids[rd_idx[g]];
  end
endmodule

// File: rtl/ssp_last_store.sv
module ssp_last_store #(
  parameter int ID_W  = 4,
  parameter int TAG_W = 6,
  parameter int SETS  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [ID_W-1:0]  rd_id,
  output logic             rd_vld,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             set_en,
  input  logic [ID_W-1:0]  set_id,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             inv_en,
  input  logic [ID_W-1:0]  inv_id,
  input  logic [TAG_W-1:0] inv_tag
);
  logic [SETS-1:0]  vld_all;
  logic [TAG_W-1:0] tag_all [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_ent
    logic             v_q;
    logic [TAG_W-1:0] t_q;
    logic             hit_set;
    logic             hit_inv;

    assign hit_set = set_en && (set_id == ID_W'(g));
    assign hit_inv = inv_en && (inv_id == ID_W'(g)) && (t_q == inv_tag);

    // a rename into this set beats a same-cycle execute
    always_ff @(posedge clk) begin
      if (!rst_n || clr) v_q <= 1'b0;
      else if (hit_set)  v_q <= 1'b1;
      else if (hit_inv)  v_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (hit_set) t_q <= set_tag;
    end

    assign vld_all[g] = v_q;
    assign tag_all[g] = t_q;
  end

  assign rd_vld = vld_all[rd_id];
  assign rd_tag = tag_all[rd_id];
endmodule

// File: rtl/ssp_viol_ctrl.sv
module ssp_viol_ctrl
  import ssp_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            viol_en,
  input  logic            ld_vld,
  input  logic [ID_W-1:0] ld_id,
  input  logic            st_vld,
  input  logic [ID_W-1:0] st_id,
  output logic            ld_we,
  output logic            st_we,
  output logic [ID_W-1:0] wr_id
);
  viol_act_e       act;
  logic [ID_W-1:0] next_id;

  always_comb begin
    act = VA_NONE;
    if (viol_en) begin
      if (!ld_vld && !st_vld) act = VA_NEW;
      else if (!ld_vld)       act = VA_LD_JOIN;
      else if (!st_vld)       act = VA_ST_JOIN;
      else if (ld_id != st_id) act = VA_MERGE;
    end
  end

  always_comb begin
    ld_we = 1'b0;
    st_we = 1'b0;
    wr_id = next_id;
    case (act)
      VA_NEW: begin
        ld_we = 1'b1;
        st_we = 1'b1;
      end
      VA_LD_JOIN: begin
        ld_we = 1'b1;
        wr_id = st_id;
      end
      VA_ST_JOIN: begin
        st_we = 1'b1;
        wr_id = ld_id;
      end
      VA_MERGE: begin
        wr_id = (ld_id < st_id) ? ld_id : st_id;
        ld_we = (ld_id > st_id);
        st_we = (st_id > ld_id);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr)    next_id <= '0;
    else if (act == VA_NEW) next_id <= next_id + 1'b1;
  end
endmodule

// File: rtl/mem_dep_storeset.sv
module mem_dep_storeset #(
  parameter int PC_W              = 32,
  parameter int PC_LSB            = 2,
  parameter int SET_TABLE_ENTRIES = 64,
  parameter int SSID_W            = 4,
  parameter int TAG_W             = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_req_valid,
  input  logic [PC_W-1:0]  ld_req_pc,
  output logic             ld_wait_valid,
  output logic [TAG_W-1:0] ld_wait_tag,
  input  logic             st_req_valid,
  input  logic [PC_W-1:0]  st_req_pc,
  input  logic [TAG_W-1:0] st_req_tag,
  input  logic             st_exec_valid,
  input  logic [PC_W-1:0]  st_exec_pc,
  input  logic [TAG_W-1:0] st_exec_tag,
  input  logic             viol_valid,
  input  logic [PC_W-1:0]  viol_ld_pc,
  input  logic [PC_W-1:0]  viol_st_pc,
  input  logic             clear
);
  localparam int IDX_W = $clog2(SET_TABLE_ENTRIES);
  localparam int NSETS = 1 << SSID_W;
  localparam int NRD   = 5;
  localparam int HI    = PC_LSB + IDX_W;

  logic [IDX_W-1:0]  rd_idx [NRD];
  logic              rd_vld [NRD];
  logic [SSID_W-1:0] rd_id  [NRD];

  // read port order: load lookup, store rename, store execute, violating load, violating store
  assign rd_idx[0] = ld_req_pc[PC_LSB +: IDX_W];
  assign rd_idx[1] = st_req_pc[PC_LSB +: IDX_W];
  assign rd_idx[2] = st_exec_pc[PC_LSB +: IDX_W];
  assign rd_idx[3] = viol_ld_pc[PC_LSB +: IDX_W];
  assign rd_idx[4] = viol_st_pc[PC_LSB +: IDX_W];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{ld_req_pc[PC_W-1:HI], ld_req_pc[PC_LSB-1:0],
                            st_req_pc[PC_W-1:HI], st_req_pc[PC_LSB-1:0],
                            st_exec_pc[PC_W-1:HI], st_exec_pc[PC_LSB-1:0],
                            viol_ld_pc[PC_W-1:HI], viol_ld_pc[PC_LSB-1:0],
                            viol_st_pc[PC_W-1:HI], viol_st_pc[PC_LSB-1:0]};

  logic              ld_in_set, st_in_set, ex_in_set;
  logic [SSID_W-1:0] ld_set, st_set, ex_set;
  assign ld_in_set = rd_vld[0];
  assign ld_set    = rd_id[0];
  assign st_in_set = rd_vld[1];
  assign st_set    = rd_id[1];
  assign ex_in_set = rd_vld[2];
  assign ex_set    = rd_id[2];

  logic              vio_ld_we, vio_st_we;
  logic [SSID_W-1:0] vio_wr_id;

  ssp_set_table #(
    .ENTRIES(SET_TABLE_ENTRIES), .IDX_W(IDX_W), .ID_W(SSID_W), .NRD(NRD)
  ) u_ssit (
    .clk(clk), .rst_n(rst_n), .clr(clear),
    .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_id(rd_id),
    .wa_en(vio_ld_we), .wa_idx(rd_idx[3]),
    .wb_en(vio_st_we), .wb_idx(rd_idx[4]),
    .wr_id(vio_wr_id)
  );

  ssp_viol_ctrl #(.ID_W(SSID_W)) u_vctl (
    .clk(clk), .rst_n(rst_n), .clr(clear),
    .viol_en(viol_valid),
    .ld_vld(rd_vld[3]), .ld_id(rd_id[3]),
    .st_vld(rd_vld[4]), .st_id(rd_id[4]),
    .ld_we(vio_ld_we), .st_we(vio_st_we), .wr_id(vio_wr_id)
  );

  logic             lf_vld;
  logic [TAG_W-1:0] lf_tag;

  ssp_last_store #(.ID_W(SSID_W), .TAG_W(TAG_W), .SETS(NSETS)) u_lfst (
    .clk(clk), .rst_n(rst_n), .clr(clear),
    .rd_id(ld_set), .rd_vld(lf_vld), .rd_tag(lf_tag),
    .set_en(st_req_valid && st_in_set), .set_id(st_set), .set_tag(st_req_tag),
    .inv_en(st_exec_valid && ex_in_set), .inv_id(ex_set), .inv_tag(st_exec_tag)
  );

  assign ld_wait_valid = ld_req_valid && ld_in_set && lf_vld;
  assign ld_wait_tag   = ld_wait_valid ? lf_tag : '0;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int PC_W   = 32,
  parameter int SSID_W = 4,
  parameter int TAG_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear,
  input logic              ld_req_valid,
  input logic [PC_W-1:0]   ld_req_pc,
  input logic              ld_wait_valid,
  input logic [TAG_W-1:0]  ld_wait_tag,
  input logic              st_req_valid,
  input logic [PC_W-1:0]   st_req_pc,
  input logic [TAG_W-1:0]  st_req_tag,
  input logic              st_exec_valid,
  input logic [TAG_W-1:0]  st_exec_tag,
  input logic              viol_valid,
  input logic [PC_W-1:0]   viol_ld_pc,
  input logic [PC_W-1:0]   viol_st_pc,
  input logic              ld_in_set,
  input logic [SSID_W-1:0] ld_set,
  input logic              st_in_set,
  input logic [SSID_W-1:0] st_set,
  input logic              ex_in_set,
  input logic [SSID_W-1:0] ex_set
);
  // R10
  clear_wipes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !ld_wait_valid);

  // R5
  rename_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req_valid && st_in_set && !clear) |=>
      (!(ld_req_valid && ld_in_set && ld_set == $past(st_set)) ||
       (ld_wait_valid && ld_wait_tag == $past(st_req_tag))));

  // R6
  exec_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_exec_valid && ex_in_set && !clear && !st_req_valid &&
     ld_wait_valid && ld_set == ex_set && ld_wait_tag == st_exec_tag) |=>
      !(ld_req_valid && ld_in_set && ld_set == $past(ex_set) && ld_wait_valid));

  // R3
  violation_links_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && !clear) |=>
      (!(ld_req_valid && ld_req_pc == $past(viol_ld_pc) &&
         st_req_valid && st_req_pc == $past(viol_st_pc)) ||
       (ld_in_set && st_in_set && ld_set == st_set)));
endmodule

bind mem_dep_storeset ssp_checker #(
  .PC_W(PC_W), .SSID_W(SSID_W), .TAG_W(TAG_W)
) u_chk (.*);

// File: tb/mem_dep_storeset_tb.sv
module mem_dep_storeset_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W  = 32;
  localparam int TAG_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_req_valid = 0, st_req_valid = 0, st_exec_valid = 0, viol_valid = 0, clear = 0;
  logic [PC_W-1:0]  ld_req_pc = '0, st_req_pc = '0, st_exec_pc = '0, viol_ld_pc = '0, viol_st_pc = '0;
  logic [TAG_W-1:0] st_req_tag = '0, st_exec_tag = '0;
  logic             ld_wait_valid;
  logic [TAG_W-1:0] ld_wait_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_dep_storeset u_dut (
    .clk(clk), .rst_n(rst_n),
    .ld_req_valid(ld_req_valid), .ld_req_pc(ld_req_pc),
    .ld_wait_valid(ld_wait_valid), .ld_wait_tag(ld_wait_tag),
    .st_req_valid(st_req_valid), .st_req_pc(st_req_pc), .st_req_tag(st_req_tag),
    .st_exec_valid(st_exec_valid), .st_exec_pc(st_exec_pc), .st_exec_tag(st_exec_tag),
    .viol_valid(viol_valid), .viol_ld_pc(viol_ld_pc), .viol_st_pc(viol_st_pc),
    .clear(clear)
  );

  // reference model
  int    m_sv [64];
  int    m_sid[64];
  int    m_lv [16];
  int    m_lt [16];
  int    m_ctr;
  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string req = "R1";

  function automatic int ix(logic [PC_W-1:0] pc);
    return int'(pc[7:2]);
  endfunction

  function automatic logic [PC_W-1:0] pc_of(int slot);
    return 32'h0000_1000 + slot * 4;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 64; i++) begin m_sv[i] = 0; m_sid[i] = 0; end
    for (int i = 0; i < 16; i++) begin m_lv[i] = 0; m_lt[i] = 0; end
    m_ctr = 0;
  endtask

  task automatic model_step();
    if (clear) begin
      model_reset();
      return;
    end
    if (st_exec_valid && m_sv[ix(st_exec_pc)] != 0) begin
      int s = m_sid[ix(st_exec_pc)];
      if (m_lv[s] != 0 && m_lt[s] == int'(st_exec_tag)) m_lv[s] = 0;
    end
    if (st_req_valid && m_sv[ix(st_req_pc)] != 0) begin
      int s = m_sid[ix(st_req_pc)];
      m_lv[s] = 1;
      m_lt[s] = int'(st_req_tag);
    end
    if (viol_valid) begin
      int li = ix(viol_ld_pc);
      int si = ix(viol_st_pc);
      int lv = m_sv[li];
      int sv = m_sv[si];
      int lid = m_sid[li];
      int sid = m_sid[si];
      if (lv == 0 && sv == 0) begin
        m_sv[li] = 1; m_sid[li] = m_ctr;
        m_sv[si] = 1; m_sid[si] = m_ctr;
        m_ctr = (m_ctr + 1) % 16;
      end else if (lv == 0) begin
        m_sv[li] = 1; m_sid[li] = sid;
      end else if (sv == 0) begin
        m_sv[si] = 1; m_sid[si] = lid;
      end else if (lid != sid) begin
        int mn = (lid < sid) ? lid : sid;
        m_sid[li] = mn; m_sid[si] = mn;
      end
    end
  endtask

  task automatic idle();
    ld_req_valid = 0; st_req_valid = 0; st_exec_valid = 0; viol_valid = 0; clear = 0;
  endtask

  // compare, advance one clock, update model; called with inputs set just after a falling edge
  task automatic tick();
    int          ev;
    int          et;
    logic [TAG_W-1:0] exp_tag;
    #1;
    ev = 0; et = 0;
    if (ld_req_valid && m_sv[ix(ld_req_pc)] != 0 && m_lv[m_sid[ix(ld_req_pc)]] != 0) begin
      ev = 1;
      et = m_lt[m_sid[ix(ld_req_pc)]];
    end
    exp_tag = TAG_W'(et);
    checks++;
    if (ld_wait_valid !== ev[0] || ld_wait_tag !== exp_tag) begin
      failures++;
      $display("FAIL %s: pc=%h wait=%b tag=%0d expected wait=%0d tag=%0d",
               req, ld_req_pc, ld_wait_valid, ld_wait_tag, ev, et);
    end
    @(posedge clk);
    model_step();
    @(negedge clk);
    idle();
  endtask

  task automatic look(logic [PC_W-1:0] pc);
    ld_req_valid = 1; ld_req_pc = pc;
    tick();
  endtask

  task automatic violate(logic [PC_W-1:0] lpc, logic [PC_W-1:0] spc);
    viol_valid = 1; viol_ld_pc = lpc; viol_st_pc = spc;
    tick();
  endtask

  task automatic rename(logic [PC_W-1:0] pc, int tag);
    st_req_valid = 1; st_req_pc = pc; st_req_tag = TAG_W'(tag);
    tick();
  endtask

  task automatic execute(logic [PC_W-1:0] pc, int tag);
    st_exec_valid = 1; st_exec_pc = pc; st_exec_tag = TAG_W'(tag);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: nothing learned yet
    req = "R1";
    for (int s = 0; s < 8; s++) look(pc_of(s));
    violate(pc_of(1), pc_of(2));
    req = "R1";
    look(pc_of(1));

    // R3: fresh allocations
    req = "R3";
    violate(pc_of(3), pc_of(4));
    rename(pc_of(4), 21);
    look(pc_of(3));

    // R5: rename recorded only for trained stores
    req = "R5";
    rename(pc_of(2), 5);
    look(pc_of(1));
    rename(pc_of(5), 9);
    look(pc_of(1));

    // R4: same-cycle rename not seen by the lookup
    req = "R4";
    st_req_valid = 1; st_req_pc = pc_of(2); st_req_tag = 7;
    ld_req_valid = 1; ld_req_pc = pc_of(1);
    tick();
    look(pc_of(1));

    // R2: aliasing address shares training
    req = "R2";
    look(pc_of(1) + 256);
    look(pc_of(1) + 32'h0010_0000);

    // R6: execute with wrong tag, right tag, and rename collision
    req = "R6";
    execute(pc_of(2), 3);
    look(pc_of(1));
    execute(pc_of(2), 7);
    look(pc_of(1));
    st_req_valid = 1; st_req_pc = pc_of(2); st_req_tag = 8;
    st_exec_valid = 1; st_exec_pc = pc_of(2); st_exec_tag = 8;
    tick();
    look(pc_of(1));

    // R7: load joins the store's set
    req = "R7";
    violate(pc_of(6), pc_of(2));
    look(pc_of(6));

    // R8: store joins the load's set
    req = "R8";
    violate(pc_of(3), pc_of(7));
    rename(pc_of(7), 11);
    look(pc_of(3));

    // R9: merge into the smaller id
    req = "R9";
    violate(pc_of(3), pc_of(2));
    rename(pc_of(4), 12);
    look(pc_of(3));
    violate(pc_of(6), pc_of(2));
    look(pc_of(6));

    // R10: clear overrides a same-cycle rename and resets the counter
    req = "R10";
    clear = 1; st_req_valid = 1; st_req_pc = pc_of(2); st_req_tag = 30;
    viol_valid = 1; viol_ld_pc = pc_of(8); viol_st_pc = pc_of(9);
    tick();
    look(pc_of(1));
    look(pc_of(8));
    violate(pc_of(10), pc_of(11));
    rename(pc_of(11), 2);
    look(pc_of(10));

    // R11: no request, no answer
    req = "R11";
    ld_req_valid = 0; ld_req_pc = pc_of(10);
    tick();

    // R3: counter wrap over many fresh pairs
    req = "R3";
    for (int k = 0; k < 18; k++) begin
      violate(pc_of(16 + 2*k), pc_of(17 + 2*k));
      rename(pc_of(17 + 2*k), k);
      look(pc_of(16 + 2*k));
    end

    // R4: mixed traffic over a small aliasing pool
    req = "R4";
    clear = 1;
    tick();
    for (int n = 0; n < 5000; n++) begin
      int pick [6];
      for (int j = 0; j < 6; j++) begin
        int s = int'($urandom_range(0, 9));
        pick[j] = s;
      end
      ld_req_valid  = ($urandom_range(0, 3) != 0);
      ld_req_pc     = pc_of(pick[0]) + (($urandom_range(0, 1) != 0) ? 256 : 0);
      st_req_valid  = ($urandom_range(0, 2) == 0);
      st_req_pc     = pc_of(pick[1]);
      st_req_tag    = TAG_W'($urandom_range(0, 3));
      st_exec_valid = ($urandom_range(0, 2) == 0);
      st_exec_pc    = pc_of(pick[2]);
      st_exec_tag   = TAG_W'($urandom_range(0, 3));
      viol_valid    = ($urandom_range(0, 9) == 0);
      viol_ld_pc    = pc_of(pick[3]);
      viol_st_pc    = pc_of(pick[4]);
      clear         = ($urandom_range(0, 299) == 0);
      tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule